// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block carries one complete I2C message, either a write or a read, through an existing byte-level bus controller without any help from software. The controller raises a status event after each byte phase. On each event the sequencer answers in one cycle: it writes a data byte, reads a received byte, issues a command or changes the interrupt-enable mask. It also clears the status bits it has handled and moves bytes between the message buffer and the controller's data register.

A transfer starts with a pulse on `start`, together with a 7-bit target address, a direction flag and a byte count. A signed position counter keeps track of progress. It starts at -1, the address phase. During a read, received bytes land two positions behind the counter, because the controller returns each byte one event late. When the last event has been handled, the sequencer polls the controller's busy flag. The poll is bounded in both interval and number of retries. The sequencer then pulses `done`, with `err` set if the target failed to acknowledge, if arbitration was lost, or if the poll ran out of retries.

Top module: `i2c_msg_seq`

## Requirements
- R1: A `start` pulse while idle, other than a zero-length read, writes the interrupt mask 4'hF (bit0 data-empty, bit1 wait, bit2 arbitration-lost, bit3 no-acknowledge; the same bit order is used by `ev_stat` and `stat_clr_mask`) and issues command code 0 (start), both in the cycle after the pulse.
- R2: The first event sends the byte {addr7, rd_req} through `dat_wr`. Unless that byte is also the last byte of a write, the same event writes the interrupt mask 4'b1110, which turns off data-empty.
- R3: In a write, the event at position p (0 ≤ p < len) sends buffer byte p. At p = len-1, and also for the address byte when len = 0, the same event issues command code 1 (stop after this byte).
- R4: In a write, the event at position len performs no data action, and the sequencer moves on to busy polling.
- R5: In a read, the event at position 0 issues command code 2 (switch to receive) and moves no data.
- R6: In a read, each event at position p ≥ 1 strobes `dat_rd`. The byte read is stored at buffer index p-2 when that index is not negative, and is discarded when it is negative.
- R7: In a read, the event at position len also writes the interrupt mask 4'hF and issues command code 3 (stop after receive).
- R8: A read moves on to busy polling after the event at position len+1.
- R9: An event carrying the arbitration-lost or no-acknowledge bit clears those bits. It moves no data, issues no command and leaves the position unchanged. The `err` flag reported at `done` is then set.
- R10: Every event that carries the wait bit clears it through `stat_clr`.
- R11: `done` is raised only after `ctl_busy` has been seen low. Busy is rechecked every POLL_GAP+1 cycles. After POLL_TRIES retries that still see busy high, `done` is raised with `err` set.
- R12: A read request with len = 0 is refused. `done` and `err` rise in the next cycle, and no command, data or mask strobe is issued.
- R13: `done` is a single-cycle pulse. While the sequencer is idle, events have no effect on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a message (sampled while idle) |
| addr7 | input | 7 | Target address |
| rd_req | input | 1 | 1 = read message, 0 = write message |
| len | input | LEN_W | Number of data bytes |
| active | output | 1 | A message is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error result, valid with done |
| ev_valid | input | 1 | Controller status event |
| ev_stat | input | 4 | Event status bits {no-ack, arb-lost, wait, data-empty} |
| ctl_busy | input | 1 | Controller bus-busy flag |
| cmd_wr | output | 1 | Command strobe |
| cmd_code | output | 2 | 0 start, 1 stop after write, 2 switch to receive, 3 stop after receive |
| ie_wr | output | 1 | Interrupt-enable write strobe |
| ie_mask | output | 4 | Interrupt-enable value |
| dat_wr | output | 1 | Data-register write strobe |
| dat_wdata | output | 8 | Byte to transmit |
| dat_rd | output | 1 | Data-register read strobe |
| dat_rdata | input | 8 | Data-register contents |
| stat_clr | output | 1 | Status clear strobe |
| stat_clr_mask | output | 4 | Status bits to clear |
| buf_ridx | output | LEN_W | Buffer read index (current position) |
| buf_rdata | input | 8 | Buffer byte at buf_ridx, combinational |
| buf_we | output | 1 | Buffer write strobe |
| buf_widx | output | LEN_W | Buffer write index |
| buf_wdata | output | 8 | Buffer write byte |

## Verification
A wrong position counter shows up in the cycle after the next event. The byte on `dat_wdata` is then taken from the wrong buffer entry, a command lands one event early or late, or a received byte is stored at the wrong index. A finish decision made at the wrong point leaves the sequencer waiting for events that never come, or raises `done` before the last read. The bench therefore compares every strobe and field after every event against values worked out from the position rules. A latched error or poll count that is wrong appears only at `done`, in the value of `err` and in how long `done` takes to arrive.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_WSTOP = 2'd1,
        CMD_TORX  = 2'd2,
        CMD_RSTOP = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_POLL = 2'd2
    } st_e;

    localparam int SB_DTE  = 0;
    localparam int SB_WAIT = 1;
    localparam int SB_AL   = 2;
    localparam int SB_NACK = 3;

    localparam logic [3:0] IE_ALL   = 4'b1111;
    localparam logic [3:0] IE_NODTE = 4'b1110;

    typedef struct packed {
        logic       cmd_wr;
        cmd_e       cmd;
        logic       ie_wr;
        logic [3:0] ie;
        logic       dat_wr;
        logic [7:0] wdata;
        logic       dat_rd;
        logic       store;
        logic       clr;
        logic [3:0] clr_mask;
        logic       adv;
        logic       finish;
        logic       err_ev;
    } act_t;

endpackage

// File: rtl/i2cseq_step.sv
module i2cseq_step
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic                    rd,
    input  logic [LEN_W-1:0]        len,
    input  logic signed [LEN_W+1:0] pos,
    input  logic [3:0]              stat,
    input  logic [6:0]              addr,
    input  logic [7:0]              buf_rdata,
    output act_t                    act,
    output logic [LEN_W-1:0]        store_idx
);
    localparam int POS_W = LEN_W + 2;
    localparam logic signed [POS_W-1:0] ONE  = POS_W'(1);
    localparam logic signed [POS_W-1:0] TWO  = POS_W'(2);
    localparam logic signed [POS_W-1:0] NEG1 = -POS_W'(1);

    logic signed [POS_W-1:0] len_s, last_s, back_s, next_s, stop_s;
    logic [7:0] addr_byte;

    assign len_s     = signed'({2'b00, len});
    assign last_s    = len_s - ONE;
    assign back_s    = pos - TWO;
    assign next_s    = pos + ONE;
    assign stop_s    = len_s + TWO;
    assign addr_byte = {addr, rd};
    assign store_idx = back_s[LEN_W-1:0];

    always_comb begin
        act          = '0;
        act.clr_mask = {stat[SB_NACK], stat[SB_AL], stat[SB_WAIT], 1'b0};
        act.clr      = |act.clr_mask;
        act.err_ev   = stat[SB_AL] | stat[SB_NACK];
        if (act.err_ev) begin
            act.adv = 1'b0;
        end else if (!rd) begin
            if (pos == len_s) begin
                act.finish = 1'b1;
            end else begin
                act.adv    = 1'b1;
                act.dat_wr = 1'b1;
                act.wdata  = (pos < 0) ? addr_byte : buf_rdata;
                if (pos == last_s) begin
                    act.cmd_wr = 1'b1;
                    act.cmd    = CMD_WSTOP;
                end else if (pos == NEG1) begin
                    act.ie_wr = 1'b1;
                    act.ie    = IE_NODTE;
                end
            end
        end else begin
            act.adv = 1'b1;
            if (pos < 0) begin
                act.dat_wr = 1'b1;
                act.wdata  = addr_byte;
                act.ie_wr  = 1'b1;
                act.ie     = IE_NODTE;
            end else if (pos == 0) begin
                act.cmd_wr = 1'b1;
                act.cmd    = CMD_TORX;
            end else begin
                if (pos == len_s) begin
                    act.ie_wr  = 1'b1;
                    act.ie     = IE_ALL;
                    act.cmd_wr = 1'b1;
                    act.cmd    = CMD_RSTOP;
                end
                act.dat_rd = 1'b1;
                act.store  = (back_s >= 0);
            end
            act.finish = (next_s == stop_s);
        end
    end

endmodule

// File: rtl/i2cseq_poll.sv
module i2cseq_poll #(
    parameter int POLL_GAP   = 2500,
    parameter int POLL_TRIES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic busy,
    output logic fin,
    output logic tout
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int TW = $clog2(POLL_TRIES + 1);

    typedef struct packed {
        logic          on;
        logic [GW-1:0] gap;
        logic [TW-1:0] tries;
    } poll_t;

    poll_t poll_q, poll_d;

    always_comb begin
        poll_d = poll_q;
        fin    = 1'b0;
        tout   = 1'b0;
        if (go) begin
            poll_d.on    = 1'b1;
            poll_d.gap   = '0;
            poll_d.tries = '0;
        end else if (poll_q.on) begin
            if (poll_q.gap != '0) begin
                poll_d.gap = poll_q.gap - 1'b1;
            end else if (!busy) begin
                fin       = 1'b1;
                poll_d.on = 1'b0;
            end else if (poll_q.tries == TW'(POLL_TRIES)) begin
                fin       = 1'b1;
                tout      = 1'b1;
                poll_d.on = 1'b0;
            end else begin
                poll_d.tries = poll_q.tries + 1'b1;
                poll_d.gap   = GW'(POLL_GAP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) poll_q <= '0;
        else        poll_q <= poll_d;
    end

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2cseq_pkg::*;
#(
    parameter int LEN_W      = 4,
    parameter int POLL_GAP   = 2500,
    parameter int POLL_TRIES = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [6:0]       addr7,
    input  logic             rd_req,
    input  logic [LEN_W-1:0] len,
    output logic             active,
    output logic             done,
    output logic             err,
    input  logic             ev_valid,
    input  logic [3:0]       ev_stat,
    input  logic             ctl_busy,
    output logic             cmd_wr,
    output logic [1:0]       cmd_code,
    output logic             ie_wr,
    output logic [3:0]       ie_mask,
    output logic             dat_wr,
    output logic [7:0]       dat_wdata,
    output logic             dat_rd,
    input  logic [7:0]       dat_rdata,
    output logic             stat_clr,
    output logic [3:0]       stat_clr_mask,
    output logic [LEN_W-1:0] buf_ridx,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [LEN_W-1:0] buf_widx,
    output logic [7:0]       buf_wdata
);
    localparam int POS_W = LEN_W + 2;

    typedef struct packed {
        st_e                     st;
        logic signed [POS_W-1:0] pos;
        logic [LEN_W-1:0]        len;
        logic                    rd;
        logic [6:0]              addr;
        logic                    err;
        logic                    done;
        logic                    cmd_wr;
        cmd_e                    cmd;
        logic                    ie_wr;
        logic [3:0]              ie;
        logic                    dat_wr;
        logic [7:0]              wdata;
        logic                    dat_rd;
        logic                    clr;
        logic [3:0]              clr_mask;
        logic                    bwe;
        logic [LEN_W-1:0]        bidx;
        logic [7:0]              bdata;
    } seq_t;

    seq_t             seq_q, seq_d;
    act_t             act;
    logic [LEN_W-1:0] store_idx;
    logic             poll_go, poll_fin, poll_tout;

    i2cseq_step #(.LEN_W(LEN_W)) u_step (
        .rd        (seq_q.rd),
        .len       (seq_q.len),
        .pos       (seq_q.pos),
        .stat      (ev_stat),
        .addr      (seq_q.addr),
        .buf_rdata (buf_rdata),
        .act       (act),
        .store_idx (store_idx)
    );

    i2cseq_poll #(.POLL_GAP(POLL_GAP), .POLL_TRIES(POLL_TRIES)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (poll_go),
        .busy  (ctl_busy),
        .fin   (poll_fin),
        .tout  (poll_tout)
    );

    always_comb begin
        seq_d          = seq_q;
        seq_d.done     = 1'b0;
        seq_d.cmd_wr   = 1'b0;
        seq_d.cmd      = CMD_START;
        seq_d.ie_wr    = 1'b0;
        seq_d.ie       = '0;
        seq_d.dat_wr   = 1'b0;
        seq_d.wdata    = '0;
        seq_d.dat_rd   = 1'b0;
        seq_d.clr      = 1'b0;
        seq_d.clr_mask = '0;
        seq_d.bwe      = 1'b0;
        seq_d.bidx     = '0;
        seq_d.bdata    = '0;
        poll_go        = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (rd_req && len == '0) begin
                        seq_d.done = 1'b1;
                        seq_d.err  = 1'b1;
                    end else begin
                        seq_d.st     = ST_RUN;
                        seq_d.pos    = '1;
                        seq_d.len    = len;
                        seq_d.rd     = rd_req;
                        seq_d.addr   = addr7;
                        seq_d.err    = 1'b0;
                        seq_d.cmd_wr = 1'b1;
                        seq_d.cmd    = CMD_START;
                        seq_d.ie_wr  = 1'b1;
                        seq_d.ie     = IE_ALL;
                    end
                end
            end
            ST_RUN: begin
                if (ev_valid) begin
                    seq_d.cmd_wr   = act.cmd_wr;
                    seq_d.cmd      = act.cmd;
                    seq_d.ie_wr    = act.ie_wr;
                    seq_d.ie       = act.ie;
                    seq_d.dat_wr   = act.dat_wr;
                    seq_d.wdata    = act.wdata;
                    seq_d.dat_rd   = act.dat_rd;
                    seq_d.clr      = act.clr;
                    seq_d.clr_mask = act.clr_mask;
                    if (act.store) begin
                        seq_d.bwe   = 1'b1;
                        seq_d.bidx  = store_idx;
                        seq_d.bdata = dat_rdata;
                    end
                    if (act.adv)    seq_d.pos = seq_q.pos + POS_W'(1);
                    if (act.err_ev) seq_d.err = 1'b1;
                    if (act.finish) begin
                        seq_d.st = ST_POLL;
                        poll_go  = 1'b1;
                    end
                end
            end
            ST_POLL: begin
                if (poll_fin) begin
                    seq_d.done = 1'b1;
                    seq_d.err  = seq_q.err | poll_tout;
                    seq_d.st   = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign active        = (seq_q.st != ST_IDLE);
    assign done          = seq_q.done;
    assign err           = seq_q.err;
    assign cmd_wr        = seq_q.cmd_wr;
    assign cmd_code      = seq_q.cmd;
    assign ie_wr         = seq_q.ie_wr;
    assign ie_mask       = seq_q.ie;
    assign dat_wr        = seq_q.dat_wr;
    assign dat_wdata     = seq_q.wdata;
    assign dat_rd        = seq_q.dat_rd;
    assign stat_clr      = seq_q.clr;
    assign stat_clr_mask = seq_q.clr_mask;
    assign buf_ridx      = seq_q.pos[LEN_W-1:0];
    assign buf_we        = seq_q.bwe;
    assign buf_widx      = seq_q.bidx;
    assign buf_wdata     = seq_q.bdata;

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_req,
    input logic [LEN_W-1:0] len,
    input logic             active,
    input logic             done,
    input logic             err,
    input logic             ev_valid,
    input logic [3:0]       ev_stat,
    input logic             ctl_busy,
    input logic             cmd_wr,
    input logic [1:0]       cmd_code,
    input logic             ie_wr,
    input logic [3:0]       ie_mask,
    input logic             dat_wr,
    input logic             dat_rd,
    input logic             stat_clr,
    input logic             buf_we
);
    // R12
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active && rd_req && len == '0) |=> (done && err));

    // R1
    start_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == 2'd0) |-> (ie_wr && ie_mask == 4'hF));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !(dat_wr || dat_rd || cmd_wr || ie_wr || buf_we));

    // R6
    store_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> dat_rd);

    // R6
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_wr && dat_rd));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev_valid && (ev_stat[2] || ev_stat[3]))
        |=> (stat_clr && !dat_wr && !dat_rd && !cmd_wr));

    // R11
    done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && active == 1'b0 && $past(active)) |-> $past(!ctl_busy));

endmodule

bind i2c_msg_seq i2cseq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk, .rst_n, .start, .rd_req, .len, .active, .done, .err, .ev_valid,
    .ev_stat, .ctl_busy, .cmd_wr, .cmd_code, .ie_wr, .ie_mask, .dat_wr,
    .dat_rd, .stat_clr, .buf_we
);

// File: tb/test_i2c_msg_seq.sv
module test_i2c_msg_seq;
    localparam int LW    = 4;
    localparam int GAP   = 4;
    localparam int TRIES = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [6:0]    addr7 = 7'h52;
    logic          rd_req = 1'b0;
    logic [LW-1:0] len = '0;
    logic          active, done, err;
    logic          ev_valid = 1'b0;
    logic [3:0]    ev_stat = '0;
    logic          ctl_busy = 1'b0;
    logic          cmd_wr, ie_wr, dat_wr, dat_rd, stat_clr, buf_we;
    logic [1:0]    cmd_code;
    logic [3:0]    ie_mask, stat_clr_mask;
    logic [7:0]    dat_wdata, buf_wdata, buf_rdata;
    logic [7:0]    dat_rdata = '0;
    logic [LW-1:0] buf_ridx, buf_widx;
    logic [7:0]    bufm [16];

    int  errors = 0;
    int  checks = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    assign buf_rdata = bufm[buf_ridx];

    i2c_msg_seq #(.LEN_W(LW), .POLL_GAP(GAP), .POLL_TRIES(TRIES)) i_i2c_msg_seq (
        .clk, .rst_n, .start, .addr7, .rd_req, .len, .active, .done, .err,
        .ev_valid, .ev_stat, .ctl_busy, .cmd_wr, .cmd_code, .ie_wr, .ie_mask,
        .dat_wr, .dat_wdata, .dat_rd, .dat_rdata, .stat_clr, .stat_clr_mask,
        .buf_ridx, .buf_rdata, .buf_we, .buf_widx, .buf_wdata
    );

    // {rd, len[3:0], err_at[4:0] (31 = none), busy_hold[7:0] (255 = stuck), exp_err}
    localparam logic [18:0] VEC [9] = '{
        {1'b0, 4'd3, 5'd31, 8'd0,   1'b0},
        {1'b0, 4'd1, 5'd31, 8'd3,   1'b0},
        {1'b0, 4'd0, 5'd31, 8'd0,   1'b0},
        {1'b1, 4'd1, 5'd31, 8'd0,   1'b0},
        {1'b1, 4'd2, 5'd31, 8'd2,   1'b0},
        {1'b1, 4'd4, 5'd31, 8'd0,   1'b0},
        {1'b0, 4'd2, 5'd2,  8'd0,   1'b1},
        {1'b1, 4'd3, 5'd1,  8'd0,   1'b1},
        {1'b0, 4'd1, 5'd31, 8'd255, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] out_vec();
        return {cmd_wr, cmd_code, ie_wr, ie_mask, dat_wr, dat_wdata, dat_rd,
                buf_we, buf_widx, buf_wdata, stat_clr, stat_clr_mask};
    endfunction

    function automatic logic [35:0] exp_vec(input logic rd, input int n, input int pos,
                                            input logic [3:0] st, input logic [7:0] rxb,
                                            output string tag);
        logic cw = 0, iw = 0, dw = 0, dr = 0, we = 0;
        logic [1:0] cc = 0;
        logic [3:0] im = 0, cm;
        logic [7:0] wd = 0, bd = 0;
        logic [3:0] bi = 0;
        int back;
        cm = {st[3], st[2], st[1], 1'b0};
        tag = "R2";
        if (!rd) begin
            if (pos == n) begin
                tag = "R4";
            end else begin
                dw = 1;
                wd = (pos < 0) ? {addr7, 1'b0} : bufm[pos];
                tag = (pos < 0) ? "R2" : "R3";
                if (pos == n - 1) begin cw = 1; cc = 2'd1; end
                else if (pos == -1) begin iw = 1; im = 4'b1110; end
            end
        end else begin
            back = pos - 2;
            if (pos < 0) begin
                dw = 1; wd = {addr7, 1'b1}; iw = 1; im = 4'b1110; tag = "R2";
            end else if (pos == 0) begin
                cw = 1; cc = 2'd2; tag = "R5";
            end else begin
                dr = 1; tag = "R6";
                if (pos == n) begin iw = 1; im = 4'hF; cw = 1; cc = 2'd3; tag = "R7"; end
                if (pos == n + 1) tag = "R8";
                if (back >= 0) begin we = 1; bi = back[3:0]; bd = rxb; end
            end
        end
        return {cw, cc, iw, im, dw, wd, dr, we, bi, bd, |cm, cm};
    endfunction

    task automatic run_vec(input logic [18:0] v);
        logic       vrd;
        int         n, err_at, hold, nev, cnt;
        logic       xerr;
        logic [3:0] st;
        logic [7:0] rxb;
        logic [35:0] e;
        string      tag;
        vrd = v[18]; n = int'(v[17:14]); err_at = int'(v[13:9]);
        hold = int'(v[8:1]); xerr = v[0];
        nev = vrd ? n + 3 : n + 2;
        @(negedge clk);
        start = 1; rd_req = vrd; len = v[17:14];
        @(negedge clk);
        start = 0;
        check(cmd_wr && cmd_code == 2'd0 && ie_wr && ie_mask == 4'hF && active,
              "R1 start", {cmd_wr, cmd_code, ie_wr, ie_mask}, {1'b1, 2'd0, 1'b1, 4'hF});
        for (int j = 0; j < nev; j++) begin
            if (j == err_at) begin
                ev_valid = 1; ev_stat = 4'b1000;
                @(negedge clk);
                check(out_vec() == {28'd0, 1'b1, 4'b1000}, "R9 err event", 64'(out_vec()),
                      64'({28'd0, 1'b1, 4'b1000}));
            end
            st  = (j == 0 || j == nev - 1) ? 4'b0001 : 4'b0010;
            rxb = 8'hC0 + 8'(j);
            if (j == nev - 1) ctl_busy = (hold != 0);
            ev_valid = 1; ev_stat = st; dat_rdata = rxb;
            @(negedge clk);
            e = exp_vec(vrd, n, j - 1, st, rxb, tag);
            check(out_vec() == e, tag, 64'(out_vec()), 64'(e));
            if (st[1]) check(stat_clr && stat_clr_mask[1], "R10 wait clear",
                             64'(stat_clr_mask), 64'(4'b0010));
        end
        ev_valid = 0; ev_stat = 0;
        cnt = 0;
        while (!done && cnt < 200) begin
            cnt++;
            if (hold != 255 && cnt >= hold) ctl_busy = 0;
            @(negedge clk);
        end
        if (hold == 255) begin
            check(done && err && cnt >= TRIES * GAP, "R11 poll timeout", 64'({done, err}), 64'(2'b11));
        end else begin
            check(done && cnt >= hold, "R11 done after busy low", 64'(cnt), 64'(hold));
            check(err == xerr, xerr ? "R9 err at done" : "R4/R8 clean done", 64'(err), 64'(xerr));
        end
        ctl_busy = 0;
        @(negedge clk);
        check(!done && !active, "R13 done pulse", 64'({done, active}), 64'(0));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) bufm[i] = 8'h3 + 8'(i * 29);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!active && !done && !cmd_wr && !dat_wr && !ie_wr && !buf_we,
              "reset state", 64'({active, done, cmd_wr, dat_wr, ie_wr, buf_we}), 64'(0));
        for (int k = 0; k < 9; k++) run_vec(VEC[k]);

        // R12: zero-length read refused
        @(negedge clk);
        start = 1; rd_req = 1; len = 0;
        @(negedge clk);
        start = 0;
        check(done && err && !active && !cmd_wr && !ie_wr && !dat_wr && !dat_rd,
              "R12 zero read", 64'({done, err, active, cmd_wr, ie_wr, dat_wr, dat_rd}),
              64'(7'b1100000));
        @(negedge clk);
        check(!done && !cmd_wr && !dat_wr, "R12 no bus activity", 64'({done, cmd_wr, dat_wr}), 64'(0));

        // R13: events in idle ignored
        ev_valid = 1; ev_stat = 4'b0011;
        @(negedge clk);
        ev_valid = 0; ev_stat = 0;
        check(out_vec() == '0 && !active, "R13 idle event", 64'(out_vec()), 64'(0));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule